// File: doc/BRIEF.md
# Remote DMA Command Engine

This block moves bytes between a host data port and a byte-addressed local packet memory. Software sets a current remote address and a remaining byte count through an 8-bit register port, one byte register at a time. It then writes a 3-bit command code. A read command fetches memory contents and offers them on the host read port. A write command accepts host words and stores them. Any code with the top bit set aborts the transfer in progress.

Each transfer moves one byte, or two bytes in word mode. The current address steps up by the amount moved and the remaining count steps down by the same amount. When the count reaches zero the engine returns to idle and sets a sticky completion flag. That flag drives the interrupt line. A configuration bit selects which host lane carries the byte at the lower memory address. After an abort the count reads zero and the address is left where the transfer stopped.

The controller has five states. `S_IDLE` waits for a command. `S_RD_FETCH` drives a memory read. `S_RD_LATCH` captures the returned data one cycle later. `S_RD_OFFER` holds the host read data valid until it is taken. `S_WR_ACCEPT` signals ready and writes each host word it receives.

The transitions are:
- idle to fetch on a read command with a non-zero count
- idle to accept on a write command with a non-zero count
- fetch to latch, always
- latch to offer, always
- offer to fetch after a handshake when bytes remain
- offer to idle after the last handshake
- accept to idle after the last handshake
- any state to idle on abort

Top module: `rdma_engine`

## Requirements
- R1: After reset the current address and remaining count read 0, the completion flag and `irq` are 0, and `hd_rvalid`, `hd_wready`, `mem_re` and `mem_we` are 0.
- R2: Register offsets work as follows. Offsets 1 and 2 write the low and high byte of the current address and read back its live value. Offsets 3 and 4 do the same for the remaining count. Offset 0 takes the command in bits [2:0]. Offset 5 holds configuration: bit 0 selects word mode and bit 1 selects swapped host byte order. Offset 6 bit 0 is the completion flag.
- R3: Command 001 starts a read and 010 starts a write. Codes 000 and 011 have no effect. A write whose bit 2 is set aborts.
- R4: In byte mode each transfer moves one byte on host lane [7:0], with bit 0 of `mem_be` only. The address rises by 1 and the count falls by 1.
- R5: In word mode each transfer moves two bytes while at least two remain, and the address and count step by 2. A final odd byte moves alone and steps by 1.
- R6: With the swap bit at 0, the byte at the lower address sits on host lane [7:0]. With the swap bit at 1 it sits on [15:8]. In word mode a lone tail byte uses the lane of the lower-address byte. Memory lane [7:0] always holds `mem_addr` and lane [15:8] holds `mem_addr`+1.
- R7: A read presents `mem_re` for one cycle and uses `mem_rdata` from the following cycle. `hd_rvalid` then stays high with stable data until a cycle with `hd_rready`.
- R8: During a write `hd_wready` is high. A word is written to memory in the cycle that has `hd_wvalid` and `hd_wready` both high.
- R9: The completion flag is set when the count reaches zero. `irq` equals the flag. Writing 1 to offset 6 bit 0 clears it, writing 0 leaves it, and a new set wins over a clear.
- R10: A read or write command issued with a zero count sets the completion flag at once and moves no data.
- R11: An abort returns to idle, clears the count to 0, leaves the address at its current value and does not set the completion flag.
- R12: While a transfer is active, writes to address, count and configuration registers are ignored, and so are non-abort commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| hd_wvalid | input | 1 | Host write word valid |
| hd_wdata | input | 16 | Host write word |
| hd_wready | output | 1 | Engine ready for a host write word |
| hd_rready | input | 1 | Host takes the offered read word |
| hd_rvalid | output | 1 | Read word valid |
| hd_rdata | output | 16 | Read word to host |
| mem_addr | output | 16 | Local memory byte address |
| mem_re | output | 1 | Local memory read request |
| mem_we | output | 1 | Local memory write enable |
| mem_be | output | 2 | Byte lane enables for a write |
| mem_wdata | output | 16 | Local memory write data |
| mem_rdata | input | 16 | Local memory read data, one cycle after `mem_re` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets the following corner cases:

- **Odd tail in word mode.** This is where a design may move a stale second byte or step the address by 2 past the end.
- **Swapped-lane tail byte.** The lone byte must land on the upper lane; a wrong design puts it on the lower lane.
- **Abort mid-read with the host stalled.** An engine that rolled the address back, kept the count, or raised the completion flag is exposed here.
- **Zero-count command.** This must finish without hanging in a busy state.
- **Register writes and stray commands while busy, plus codes 000 and 011.** An engine that reloaded its address or started a transfer on these shows a moved address or spurious handshakes.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int ADDR_W = 16;
    localparam int RA_W   = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_FETCH,
        S_RD_LATCH,
        S_RD_OFFER,
        S_WR_ACCEPT
    } rdma_state_t;

    localparam logic [RA_W-1:0] RA_CMD     = 4'd0;
    localparam logic [RA_W-1:0] RA_ADDR_LO = 4'd1;
    localparam logic [RA_W-1:0] RA_ADDR_HI = 4'd2;
    localparam logic [RA_W-1:0] RA_CNT_LO  = 4'd3;
    localparam logic [RA_W-1:0] RA_CNT_HI  = 4'd4;
    localparam logic [RA_W-1:0] RA_CFG     = 4'd5;
    localparam logic [RA_W-1:0] RA_STATUS  = 4'd6;

    localparam logic [2:0] CMD_READ  = 3'b001;
    localparam logic [2:0] CMD_WRITE = 3'b010;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [7:0]      reg_wdata,
    input  logic            busy,
    input  logic            done_set,
    input  logic [AW-1:0]   cur_addr,
    input  logic [AW-1:0]   remain,
    output logic            cmd_valid,
    output logic [2:0]      cmd_code,
    output logic            ld_addr_lo,
    output logic            ld_addr_hi,
    output logic            ld_cnt_lo,
    output logic            ld_cnt_hi,
    output logic            cfg_word,
    output logic            cfg_swap,
    output logic            done_flag,
    output logic [7:0]      reg_rdata
);
    logic idle_wr;

    assign idle_wr    = reg_wr && !busy;
    assign cmd_code   = reg_wdata[2:0];
    assign cmd_valid  = reg_wr && (reg_addr == RA_CMD) && (!busy || reg_wdata[2]);
    assign ld_addr_lo = idle_wr && (reg_addr == RA_ADDR_LO);
    assign ld_addr_hi = idle_wr && (reg_addr == RA_ADDR_HI);
    assign ld_cnt_lo  = idle_wr && (reg_addr == RA_CNT_LO);
    assign ld_cnt_hi  = idle_wr && (reg_addr == RA_CNT_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word <= 1'b0;
            cfg_swap <= 1'b0;
        end else if (idle_wr && reg_addr == RA_CFG) begin
            cfg_word <= reg_wdata[0];
            cfg_swap <= reg_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (done_set) begin
            done_flag <= 1'b1;
        end else if (reg_wr && reg_addr == RA_STATUS && reg_wdata[0]) begin
            done_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        unique case (reg_addr)
            RA_ADDR_LO: reg_rdata = cur_addr[7:0];
            RA_ADDR_HI: reg_rdata = 8'(cur_addr[AW-1:8]);
            RA_CNT_LO:  reg_rdata = remain[7:0];
            RA_CNT_HI:  reg_rdata = 8'(remain[AW-1:8]);
            RA_CFG:     reg_rdata = {6'd0, cfg_swap, cfg_word};
            RA_STATUS:  reg_rdata = {7'd0, done_flag};
            default:    reg_rdata = 8'h00;
        endcase
    end

    p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> done_flag);
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({cfg_word, cfg_swap}));
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic          ld_addr_lo,
    input  logic          ld_addr_hi,
    input  logic          ld_cnt_lo,
    input  logic          ld_cnt_hi,
    input  logic [7:0]    ld_byte,
    input  logic          cfg_word,
    input  logic          hd_rready,
    input  logic          hd_wvalid,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] remain,
    output logic          step_two,
    output logic          mem_re,
    output logic          mem_we,
    output logic          hd_rvalid,
    output logic          hd_wready,
    output logic          latch_en,
    output logic          done_set
);
    rdma_state_t state, state_nx;
    logic          abort_cmd, start_rd, start_wr, step_now, last;
    logic [AW-1:0] step_amt;

    assign abort_cmd = cmd_valid && cmd_code[2];
    assign start_rd  = cmd_valid && (cmd_code == CMD_READ)  && (state == S_IDLE);
    assign start_wr  = cmd_valid && (cmd_code == CMD_WRITE) && (state == S_IDLE);
    assign step_two  = cfg_word && (remain >= AW'(2));
    assign step_amt  = step_two ? AW'(2) : AW'(1);
    assign last      = (remain == step_amt);
    assign busy      = (state != S_IDLE);
    assign step_now  = !abort_cmd &&
                       (((state == S_RD_OFFER) && hd_rready) ||
                        ((state == S_WR_ACCEPT) && hd_wvalid));
    assign done_set  = (step_now && last) ||
                       ((start_rd || start_wr) && (remain == '0));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start_rd && remain != '0)      state_nx = S_RD_FETCH;
                else if (start_wr && remain != '0) state_nx = S_WR_ACCEPT;
            end
            S_RD_FETCH: state_nx = S_RD_LATCH;
            S_RD_LATCH: state_nx = S_RD_OFFER;
            S_RD_OFFER: begin
                if (step_now) state_nx = last ? S_IDLE : S_RD_FETCH;
            end
            S_WR_ACCEPT: begin
                if (step_now && last) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
        if (abort_cmd) state_nx = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        mem_re    = (state == S_RD_FETCH);
        latch_en  = (state == S_RD_LATCH);
        hd_rvalid = (state == S_RD_OFFER);
        hd_wready = (state == S_WR_ACCEPT);
        mem_we    = (state == S_WR_ACCEPT) && step_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (step_now) begin
            cur_addr <= cur_addr + step_amt;
        end else begin
            if (ld_addr_lo) cur_addr[7:0]    <= ld_byte;
            if (ld_addr_hi) cur_addr[AW-1:8] <= (AW-8)'(ld_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (abort_cmd) begin
            remain <= '0;
        end else if (step_now) begin
            remain <= remain - step_amt;
        end else begin
            if (ld_cnt_lo) remain[7:0]    <= ld_byte;
            if (ld_cnt_hi) remain[AW-1:8] <= (AW-8)'(ld_byte);
        end
    end

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_cmd |=> (state == S_IDLE && remain == '0 && cur_addr == $past(cur_addr)));
    p_busy_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (remain != '0));
    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_now) |=> $stable(cur_addr));
    p_port_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, hd_rvalid, hd_wready}));
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !abort_cmd) |=> latch_en);
endmodule

// File: rtl/rdma_lanes.sv
module rdma_lanes (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_word,
    input  logic        cfg_swap,
    input  logic        step_two,
    input  logic        latch_en,
    input  logic [15:0] mem_rdata,
    input  logic [15:0] hd_wdata,
    output logic [15:0] mem_wdata,
    output logic [1:0]  mem_be,
    output logic [15:0] hd_rdata
);
    logic [15:0] hold;
    logic        hi_lane;
    logic [7:0]  wr_byte, rd_byte;

    assign hi_lane = cfg_word && cfg_swap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold <= '0;
        else if (latch_en) hold <= mem_rdata;
    end

    always_comb begin
        wr_byte = hi_lane ? hd_wdata[15:8] : hd_wdata[7:0];
        rd_byte = hold[7:0];
        if (step_two) begin
            mem_be    = 2'b11;
            mem_wdata = cfg_swap ? {hd_wdata[7:0], hd_wdata[15:8]} : hd_wdata;
            hd_rdata  = cfg_swap ? {hold[7:0], hold[15:8]} : hold;
        end else begin
            mem_be    = 2'b01;
            mem_wdata = {8'h00, wr_byte};
            hd_rdata  = hi_lane ? {rd_byte, 8'h00} : {8'h00, rd_byte};
        end
    end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            hd_wvalid,
    input  logic [15:0]     hd_wdata,
    output logic            hd_wready,
    input  logic            hd_rready,
    output logic            hd_rvalid,
    output logic [15:0]     hd_rdata,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_re,
    output logic            mem_we,
    output logic [1:0]      mem_be,
    output logic [15:0]     mem_wdata,
    input  logic [15:0]     mem_rdata,
    output logic            irq
);
    logic          busy, done_set, done_flag, cmd_valid, step_two, latch_en;
    logic          ld_addr_lo, ld_addr_hi, ld_cnt_lo, ld_cnt_hi, cfg_word, cfg_swap;
    logic [2:0]    cmd_code;
    logic [AW-1:0] cur_addr, remain;

    rdma_regs #(.AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .done_set(done_set),
        .cur_addr(cur_addr), .remain(remain), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi),
        .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi), .cfg_word(cfg_word),
        .cfg_swap(cfg_swap), .done_flag(done_flag), .reg_rdata(reg_rdata)
    );

    rdma_ctrl #(.AW(AW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi), .ld_cnt_lo(ld_cnt_lo),
        .ld_cnt_hi(ld_cnt_hi), .ld_byte(reg_wdata), .cfg_word(cfg_word),
        .hd_rready(hd_rready), .hd_wvalid(hd_wvalid), .busy(busy),
        .cur_addr(cur_addr), .remain(remain), .step_two(step_two),
        .mem_re(mem_re), .mem_we(mem_we), .hd_rvalid(hd_rvalid),
        .hd_wready(hd_wready), .latch_en(latch_en), .done_set(done_set)
    );

    rdma_lanes lanes_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_swap(cfg_swap),
        .step_two(step_two), .latch_en(latch_en), .mem_rdata(mem_rdata),
        .hd_wdata(hd_wdata), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .hd_rdata(hd_rdata)
    );

    assign mem_addr = cur_addr;
    assign irq      = done_flag;

    logic abort_port;
    assign abort_port = reg_wr && (reg_addr == RA_CMD) && reg_wdata[2];

    p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_rvalid && !hd_rready && !abort_port) |=> (hd_rvalid && $stable(hd_rdata)));
    p_write_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (hd_wvalid && hd_wready));
endmodule

// File: tb/rdma_engine_tb_top.sv
`timescale 1ns/1ps
module rdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        hd_wvalid = 1'b0;
    logic [15:0] hd_wdata = '0;
    logic        hd_wready;
    logic        hd_rready = 1'b0;
    logic        hd_rvalid;
    logic [15:0] hd_rdata;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [7:0]  bm [0:255];
    logic [7:0]  rm [0:255];
    logic [15:0] exp_q [$];
    logic [15:0] wbuf [0:7];

    always #2.5 clk = ~clk;

    rdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hd_wvalid(hd_wvalid),
        .hd_wdata(hd_wdata), .hd_wready(hd_wready), .hd_rready(hd_rready),
        .hd_rvalid(hd_rvalid), .hd_rdata(hd_rdata), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    // local memory model: byte lanes, one-cycle read latency
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bm[i] <= 8'(i * 7 + 3);
            mem_rdata <= '0;
        end else begin
            if (mem_re) mem_rdata <= {bm[8'(mem_addr + 16'd1)], bm[mem_addr[7:0]]};
            if (mem_we && mem_be[0]) bm[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_we && mem_be[1]) bm[8'(mem_addr + 16'd1)] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // scoreboard monitor: pops one expected word per read handshake
    always begin
        @(negedge clk);
        #1;
        if (rst_n && hd_rvalid && hd_rready) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected read word", 32'(hd_rdata), 32'hFFFF_FFFF);
            end else begin
                chk("R6 read word", 32'(hd_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic wreg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rreg16(input logic [3:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rreg(a, lo);
        rreg(a + 4'd1, hi);
        d = {hi, lo};
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] n, input logic w, input logic s);
        wreg(4'd1, a[7:0]);  wreg(4'd2, a[15:8]);
        wreg(4'd3, n[7:0]);  wreg(4'd4, n[15:8]);
        wreg(4'd5, {6'd0, s, w});
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); #1;
            if (irq) break;
        end
    endtask

    task automatic do_read(input string req, input logic [15:0] a, input int n, input logic w, input logic s);
        logic [15:0] v;
        int rem = n;
        logic [15:0] p = a;
        setup(a, 16'(n), w, s);
        while (rem > 0) begin
            if (w && rem >= 2) begin
                exp_q.push_back(s ? {rm[p[7:0]], rm[8'(p + 1)]} : {rm[8'(p + 1)], rm[p[7:0]]});
                p += 2; rem -= 2;
            end else begin
                exp_q.push_back((w && s) ? {rm[p[7:0]], 8'h00} : {8'h00, rm[p[7:0]]});
                p += 1; rem -= 1;
            end
        end
        hd_rready = 1'b1;
        wreg(4'd0, 8'h01);
        wait_irq();
        hd_rready = 1'b0;
        chk({req, " completion flag"}, 32'(irq), 1);
        chk({req, " all words seen"}, exp_q.size(), 0);
        rreg16(4'd1, v); chk({req, " end address"}, 32'(v), 32'(p));
        rreg16(4'd3, v); chk({req, " end count"}, 32'(v), 0);
        wreg(4'd6, 8'h01);
    endtask

    task automatic do_write(input string req, input logic [15:0] a, input int n, input logic w, input logic s);
        logic [15:0] v;
        int rem = n;
        logic [15:0] p = a;
        int idx = 0;
        setup(a, 16'(n), w, s);
        wreg(4'd0, 8'h02);
        while (rem > 0) begin
            if (w && rem >= 2) begin
                rm[p[7:0]]    = s ? wbuf[idx][15:8] : wbuf[idx][7:0];
                rm[8'(p + 1)] = s ? wbuf[idx][7:0]  : wbuf[idx][15:8];
                p += 2; rem -= 2;
            end else begin
                rm[p[7:0]] = (w && s) ? wbuf[idx][15:8] : wbuf[idx][7:0];
                p += 1; rem -= 1;
            end
            @(negedge clk);
            hd_wvalid = 1'b1; hd_wdata = wbuf[idx];
            #1;
            while (!hd_wready) begin @(negedge clk); #1; end
            @(negedge clk);
            hd_wvalid = 1'b0;
            idx++;
        end
        #1;
        chk({req, " completion flag"}, 32'(irq), 1);
        rreg16(4'd1, v); chk({req, " end address"}, 32'(v), 32'(p));
        for (int i = 0; i < n + 2; i++)
            chk({req, " memory byte"}, 32'(bm[8'(a + 16'(i))]), 32'(rm[8'(a + 16'(i))]));
        wreg(4'd6, 8'h01);
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        for (int i = 0; i < 256; i++) rm[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        rreg16(4'd1, v); chk("R1 address", 32'(v), 0);
        rreg16(4'd3, v); chk("R1 count", 32'(v), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 handshakes", 32'({hd_rvalid, hd_wready, mem_re, mem_we}), 0);

        // R4 byte mode write then read, R8 R9
        wbuf[0] = 16'hAA11; wbuf[1] = 16'hBB22; wbuf[2] = 16'hCC33;
        wbuf[3] = 16'hDD44; wbuf[4] = 16'hEE55;
        do_write("R4 R8 byte write", 16'h1210, 5, 1'b0, 1'b0);
        chk("R9 flag cleared by 1", 32'(irq), 0);
        do_read("R4 R7 byte read", 16'h1210, 5, 1'b0, 1'b0);

        // R9 writing 0 keeps the flag
        setup(16'h1300, 16'h0000, 1'b0, 1'b0);
        wreg(4'd0, 8'h01);
        #1; chk("R10 zero count completes", 32'(irq), 1);
        chk("R10 no data offered", 32'(hd_rvalid), 0);
        wreg(4'd6, 8'h00);
        #1; chk("R9 write 0 keeps flag", 32'(irq), 1);
        wreg(4'd6, 8'h01);

        // R5 R6 word mode
        wbuf[0] = 16'h1234; wbuf[1] = 16'h5678; wbuf[2] = 16'h9ABC;
        do_write("R5 word write", 16'h1220, 6, 1'b1, 1'b0);
        do_read("R6 swapped word read odd", 16'h1220, 5, 1'b1, 1'b1);
        wbuf[0] = 16'hC0DE; wbuf[1] = 16'h00F1;
        do_write("R5 word write odd tail", 16'h1230, 3, 1'b1, 1'b0);
        wbuf[0] = 16'hA1B2; wbuf[1] = 16'hC3D4;
        do_write("R6 swapped write odd tail", 16'h1238, 3, 1'b1, 1'b1);
        do_read("R5 word read", 16'h1230, 4, 1'b1, 1'b0);

        // R2 count bytes, R3 no-op codes, R11 abort in idle
        setup(16'h2345, 16'h0104, 1'b0, 1'b0);
        rreg(4'd3, b); chk("R2 count low", 32'(b), 32'h04);
        rreg(4'd4, b); chk("R2 count high", 32'(b), 32'h01);
        rreg(4'd5, b); chk("R2 config", 32'(b), 0);
        wreg(4'd0, 8'h00);
        wreg(4'd0, 8'h03);
        repeat (3) @(negedge clk); #1;
        chk("R3 no-op codes idle", 32'({hd_rvalid, hd_wready, mem_re}), 0);
        rreg16(4'd3, v); chk("R3 count kept", 32'(v), 32'h0104);
        wreg(4'd0, 8'h04);
        rreg16(4'd3, v); chk("R11 abort clears count", 32'(v), 0);
        rreg16(4'd1, v); chk("R11 abort keeps address", 32'(v), 32'h2345);

        // R11 abort mid-read with host stalled
        setup(16'h1240, 16'd8, 1'b0, 1'b0);
        exp_q.push_back({8'h00, rm[8'h40]});
        exp_q.push_back({8'h00, rm[8'h41]});
        wreg(4'd0, 8'h01);
        for (int t = 0; t < 2; t++) begin
            while (!hd_rvalid) begin @(negedge clk); #1; end
            @(negedge clk); hd_rready = 1'b1;
            @(negedge clk); hd_rready = 1'b0; #1;
        end
        while (!hd_rvalid) begin @(negedge clk); #1; end
        wreg(4'd0, 8'h05);
        #1;
        chk("R11 idle after abort", 32'(hd_rvalid), 0);
        chk("R11 no completion", 32'(irq), 0);
        chk("R11 queue drained", exp_q.size(), 0);
        rreg16(4'd1, v); chk("R11 address not restored", 32'(v), 32'h1242);
        rreg16(4'd3, v); chk("R11 count cleared", 32'(v), 0);

        // R12 register writes while busy
        setup(16'h1260, 16'd4, 1'b0, 1'b0);
        wreg(4'd0, 8'h02);
        wreg(4'd1, 8'h99);
        wreg(4'd5, 8'h03);
        wreg(4'd0, 8'h01);
        #1;
        rreg(4'd1, b); chk("R12 address write ignored", 32'(b), 32'h60);
        rreg(4'd5, b); chk("R12 config write ignored", 32'(b), 0);
        chk("R12 still accepting", 32'(hd_wready), 1);
        @(negedge clk); hd_wvalid = 1'b1; hd_wdata = 16'h0077;
        @(negedge clk); hd_wvalid = 1'b0;
        wreg(4'd0, 8'h07);
        #1;
        chk("R11 write abort stops", 32'(hd_wready), 0);
        chk("R8 first byte stored", 32'(bm[8'h60]), 32'h77);
        chk("R11 later byte untouched", 32'(bm[8'h61]), 32'(rm[8'h61]));
        rreg16(4'd1, v); chk("R11 address after write abort", 32'(v), 32'h1261);
        chk("R11 no completion on write abort", 32'(irq), 0);

        report();
    end
endmodule